// File: doc/BRIEF.md
# Register-Programmed Block DMA Engine

The engine copies a run of bytes between host memory and a 4 KiB buffer held inside the block. Software loads four 64-bit registers through a simple register port: a source address, a destination address, a byte count and a command word. Writing the command word with its start bit set arms the engine. After a start delay of `START_DELAY` clock cycles, the engine checks that the buffer-side address range lies inside the buffer window. It then moves the data one byte per host handshake in the requested direction. Finally it clears the start bit and, if asked, pulses an interrupt request.

The buffer is addressed through a window at 0x40000 to 0x40FFF. Host-side addresses are masked to the low `HOST_MASK_W` bits (28 by default) before they appear on the memory port. While a transfer is pending or running, all four registers refuse writes. A transfer whose buffer-side range falls outside the window, or whose count is zero, is rejected. A rejected transfer issues no memory request and raises a sticky error flag.

The sequencer has six states:
- `S_IDLE` goes to `S_DELAY` when the start bit is seen.
- `S_DELAY` counts the start delay and then goes to `S_CHECK`.
- `S_CHECK` goes to `S_MOVE` if the range is valid, and otherwise to `S_REJECT`.
- `S_MOVE` issues one host request per byte. It goes to `S_FINISH` on the acknowledge of the last byte.
- `S_FINISH` and `S_REJECT` each last one cycle and return to `S_IDLE`.

Top module: `dma_mover`

## Requirements
- R1: The registers sit at offsets 0x80 (source), 0x88 (destination), 0x90 (count) and 0x98 (command).
  - An 8-byte write (`reg_size`=8) stores all 64 bits. A 4-byte write (`reg_size`=4) stores the low 32 bits, zero-extended. A write of any other size is ignored.
  - `reg_rdata` shows the addressed register: in full for size 8, or its low 32 bits for size 4. Any other offset or size reads as all ones.
- R2: Command bit 1 selects the direction.
  - When it is 0, the engine reads host memory with `mem_rd_req` and fills the buffer from the destination's window offset.
  - When it is 1, the engine writes the buffer, starting from the source's window offset, to host memory with `mem_wr_req`.
  - One byte moves per acknowledge, at ascending addresses, and the two strobes are never high together.
- R3: While command bit 0 is set, any write to the four registers leaves them unchanged.
- R4: A command write whose bit 0 is 0 is discarded, and the command register keeps its value.
- R5: No memory request is issued sooner than `START_DELAY` cycles after the command write that starts a transfer.
- R6: Every address on `mem_addr` equals the host-side register plus the byte index, ANDed with 2^28-1. All bits from bit 28 upward are zero.
- R7: At the end of a valid transfer, command bit 0 reads 0 and the other command bits are kept. `irq_req` pulses for exactly one cycle if command bit 2 was 1, and does not pulse otherwise.
- R8: A transfer is valid only if the buffer-side range [addr, addr+count) lies within [0x40000, 0x41000) and the count is nonzero.
  - An invalid transfer makes no memory request and gives no interrupt. It clears command bit 0 and sets `err_flag`.
  - `err_flag` stays set until the next accepted start command clears it.
- R9: After reset, all four registers read 0, and `irq_req`, `err_flag`, `mem_rd_req` and `mem_wr_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| mem_rd_req | output | 1 | Host read request |
| mem_wr_req | output | 1 | Host write request |
| mem_addr | output | 64 | Masked host byte address |
| mem_wdata | output | 8 | Byte written to host |
| mem_rdata | input | 8 | Byte read from host |
| mem_ack | input | 1 | Host acknowledge, one per byte |
| irq_req | output | 1 | Completion interrupt pulse |
| err_flag | output | 1 | Sticky range-error flag |

## Verification
Directed copies are run in both directions with the same byte pattern. Filling the buffer from host memory and then writing it back to a second host region shows that both paths and the buffer offsets are correct. Window-edge cases tell an accepted range from a rejected one:
- a range ending exactly at the top of the window;
- a range one byte past it;
- an address one byte below the window;
- a zero count.

A source with high address bits set separates masked from unmasked host addressing. Random transfers, with random direction and lengths that sometimes straddle the window edges, are compared against a byte model of the buffer kept by the bench. These show that accept, reject and data placement agree over many offsets.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam logic [7:0] OFS_SRC = 8'h80;
    localparam logic [7:0] OFS_DST = 8'h88;
    localparam logic [7:0] OFS_CNT = 8'h90;
    localparam logic [7:0] OFS_CMD = 8'h98;

    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 1;
    localparam int CMD_IRQ = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DELAY,
        S_CHECK,
        S_MOVE,
        S_FINISH,
        S_REJECT
    } seq_state_t;
endpackage

// File: rtl/dma_range_chk.sv
module dma_range_chk #(
    parameter logic [63:0] WIN_BASE  = 64'h40000,
    parameter int          WIN_BYTES = 4096,
    parameter int          OFF_W     = 12
) (
    input  logic [63:0]      base,
    input  logic [63:0]      len,
    output logic             ok,
    output logic [OFF_W-1:0] offset
);
    localparam logic [64:0] WIN_END = {1'b0, WIN_BASE} + 65'(WIN_BYTES);

    logic [64:0] end_x;
    logic [63:0] rel;

    always_comb begin
        end_x  = {1'b0, base} + {1'b0, len};
        rel    = base - WIN_BASE;
        ok     = (base >= WIN_BASE) && (len != 64'd0) && (end_x <= WIN_END);
        offset = rel[OFF_W-1:0];
    end
endmodule

// File: rtl/dma_bytebuf.sv
module dma_bytebuf #(
    parameter int DEPTH = 4096,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int START_DELAY = 8,
    parameter int DLY_W       = 4,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 13,
    parameter int HOST_MASK_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             dir,
    input  logic [63:0]      src,
    input  logic [63:0]      dst,
    input  logic [63:0]      cnt,
    input  logic             range_ok,
    input  logic [OFF_W-1:0] buf_off,
    input  logic             mem_ack,
    output logic             mem_rd_req,
    output logic             mem_wr_req,
    output logic [63:0]      mem_addr,
    output logic             buf_we,
    output logic [OFF_W-1:0] buf_addr,
    output logic             done_pulse,
    output logic             fail_pulse
);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(START_DELAY - 1);
    localparam logic [63:0]      HMASK    = (64'd1 << HOST_MASK_W) - 64'd1;

    seq_state_t             state, nxt;
    logic [DLY_W-1:0]       dly;
    logic [IDX_W-1:0]       idx;
    logic                   last;
    logic [63:0]            host_base;

    assign last      = (IDX_W'(idx + 1'b1) == cnt[IDX_W-1:0]);
    assign host_base = dir ? dst : src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (run) nxt = S_DELAY;
            S_DELAY:  if (dly == DLY_LAST) nxt = S_CHECK;
            S_CHECK:  nxt = range_ok ? S_MOVE : S_REJECT;
            S_MOVE:   if (mem_ack && last) nxt = S_FINISH;
            S_FINISH: nxt = S_IDLE;
            S_REJECT: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly <= '0;
            idx <= '0;
        end else begin
            if (state == S_DELAY) dly <= dly + 1'b1;
            else                  dly <= '0;
            if (state == S_CHECK)               idx <= '0;
            else if (state == S_MOVE && mem_ack) idx <= idx + 1'b1;
        end
    end

    always_comb begin
        mem_rd_req = (state == S_MOVE) && !dir;
        mem_wr_req = (state == S_MOVE) && dir;
        mem_addr   = (host_base + 64'(idx)) & HMASK;
        buf_we     = (state == S_MOVE) && !dir && mem_ack;
        buf_addr   = buf_off + idx[OFF_W-1:0];
        done_pulse = (state == S_FINISH);
        fail_pulse = (state == S_REJECT);
    end
endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int          BUF_BYTES   = 4096,
    parameter logic [63:0] WIN_BASE    = 64'h40000,
    parameter int          START_DELAY = 8,
    parameter int          HOST_MASK_W = 28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [3:0]  reg_size,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        mem_rd_req,
    output logic        mem_wr_req,
    output logic [63:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    input  logic        mem_ack,
    output logic        irq_req,
    output logic        err_flag
);
    localparam int OFF_W = $clog2(BUF_BYTES);
    localparam int IDX_W = OFF_W + 1;
    localparam int DLY_W = (START_DELAY > 1) ? $clog2(START_DELAY) + 1 : 1;

    logic [63:0]      src_q, dst_q, cnt_q, cmd_q;
    logic             irq_q, err_q;
    logic             size_ok, wr_ok;
    logic [63:0]      wval, rsel;
    logic [63:0]      dev_base;
    logic             range_ok;
    logic [OFF_W-1:0] buf_off, buf_addr;
    logic             buf_we, done_pulse, fail_pulse;

    assign size_ok  = (reg_size == 4'd4) || (reg_size == 4'd8);
    assign wr_ok    = reg_wr && size_ok && !cmd_q[CMD_RUN];
    assign wval     = (reg_size == 4'd4) ? {32'd0, reg_wdata[31:0]} : reg_wdata;
    assign dev_base = cmd_q[CMD_DIR] ? src_q : dst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            cmd_q <= '0;
            irq_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            irq_q <= done_pulse && cmd_q[CMD_IRQ];
            if (done_pulse || fail_pulse) cmd_q[CMD_RUN] <= 1'b0;
            if (fail_pulse) err_q <= 1'b1;
            if (wr_ok) begin
                unique case (reg_addr)
                    OFS_SRC: src_q <= wval;
                    OFS_DST: dst_q <= wval;
                    OFS_CNT: cnt_q <= wval;
                    OFS_CMD: if (wval[CMD_RUN]) begin
                        cmd_q <= wval;
                        err_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_SRC: rsel = src_q;
            OFS_DST: rsel = dst_q;
            OFS_CNT: rsel = cnt_q;
            OFS_CMD: rsel = cmd_q;
            default: rsel = '1;
        endcase
        if (!size_ok)               reg_rdata = '1;
        else if (reg_size == 4'd4)  reg_rdata = {32'd0, rsel[31:0]};
        else                        reg_rdata = rsel;
    end

    dma_range_chk #(
        .WIN_BASE (WIN_BASE),
        .WIN_BYTES(BUF_BYTES),
        .OFF_W    (OFF_W)
    ) u_range (
        .base  (dev_base),
        .len   (cnt_q),
        .ok    (range_ok),
        .offset(buf_off)
    );

    dma_bytebuf #(
        .DEPTH(BUF_BYTES),
        .AW   (OFF_W)
    ) u_buf (
        .clk  (clk),
        .we   (buf_we),
        .waddr(buf_addr),
        .wdata(mem_rdata),
        .raddr(buf_addr),
        .rdata(mem_wdata)
    );

    dma_seq #(
        .START_DELAY(START_DELAY),
        .DLY_W      (DLY_W),
        .OFF_W      (OFF_W),
        .IDX_W      (IDX_W),
        .HOST_MASK_W(HOST_MASK_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cmd_q[CMD_RUN]),
        .dir       (cmd_q[CMD_DIR]),
        .src       (src_q),
        .dst       (dst_q),
        .cnt       (cnt_q),
        .range_ok  (range_ok),
        .buf_off   (buf_off),
        .mem_ack   (mem_ack),
        .mem_rd_req(mem_rd_req),
        .mem_wr_req(mem_wr_req),
        .mem_addr  (mem_addr),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .done_pulse(done_pulse),
        .fail_pulse(fail_pulse)
    );

    assign irq_req  = irq_q;
    assign err_flag = err_q;
endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk
    import dma_pkg::*;
#(
    parameter int HOST_MASK_W = 28
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [3:0]  reg_size,
    input logic [63:0] reg_wdata,
    input logic [63:0] src_q,
    input logic [63:0] cmd_q,
    input logic        mem_rd_req,
    input logic        mem_wr_req,
    input logic [63:0] mem_addr,
    input logic        irq_req,
    input logic        err_flag
);
    logic any_req;
    assign any_req = mem_rd_req || mem_wr_req;

    // R3
    src_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q[CMD_RUN] && reg_wr && reg_addr == OFS_SRC) |=> (src_q == $past(src_q)));

    // R4
    cmd_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_q[CMD_RUN] && reg_wr && reg_addr == OFS_CMD && !reg_wdata[CMD_RUN]) |=> $stable(cmd_q));

    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    // R6
    host_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> (mem_addr >> HOST_MASK_W) == 64'd0);

    // R8
    req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> (cmd_q[CMD_RUN] && !err_flag));

    // R7
    irq_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (!cmd_q[CMD_RUN] && $fell(cmd_q[CMD_RUN])));
endmodule

bind dma_mover dma_mover_chk #(.HOST_MASK_W(HOST_MASK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_size  (reg_size),
    .reg_wdata (reg_wdata),
    .src_q     (src_q),
    .cmd_q     (cmd_q),
    .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req),
    .mem_addr  (mem_addr),
    .irq_req   (irq_req),
    .err_flag  (err_flag)
);

// File: tb/sim_dma_mover.sv
module sim_dma_mover;
    localparam int CLK_PERIOD = 10;
    localparam int START_DELAY = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [3:0]  reg_size = 4'd8;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mem_rd_req, mem_wr_req;
    logic [63:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h0;
    logic        mem_ack = 1'b0;
    logic        irq_req, err_flag;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rd_hs = 0, wr_hs = 0, irq_cnt = 0, mask_bad = 0;
    int first_req = -1, cmd_cyc = 0;
    logic [63:0] first_addr = '0;
    bit finished = 0;

    logic [7:0] hmem [65536];
    logic [7:0] bmodel [4096];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_mover #(.START_DELAY(START_DELAY)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .irq_req(irq_req), .err_flag(err_flag)
    );

    // host memory responder and monitors
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (irq_req) irq_cnt = irq_cnt + 1;
        if ((mem_rd_req || mem_wr_req) && first_req < 0) begin
            first_req = cyc;
            first_addr = mem_addr;
        end
        if ((mem_rd_req || mem_wr_req) && mem_addr[63:28] != 0) mask_bad = mask_bad + 1;
        if (mem_rd_req && mem_ack) rd_hs = rd_hs + 1;
        if (mem_wr_req && mem_ack) wr_hs = wr_hs + 1;
        if (mem_wr_req && !mem_ack) hmem[mem_addr[15:0]] = mem_wdata;
        mem_rdata <= hmem[mem_addr[15:0]];
        mem_ack   <= (mem_rd_req || mem_wr_req) && !mem_ack;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [3:0] sz, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d;
        if (a == 8'h98) cmd_cyc = cyc;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, input logic [3:0] sz, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_size = sz;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [63:0] v;
        for (int i = 0; i < 20000; i++) begin
            reg_read(8'h98, 4'd8, v);
            if (!v[0]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic start(input logic [63:0] s, input logic [63:0] d, input logic [63:0] n, input logic [63:0] c);
        reg_write(8'h80, 4'd8, s);
        reg_write(8'h88, 4'd8, d);
        reg_write(8'h90, 4'd8, n);
        rd_hs = 0; wr_hs = 0; irq_cnt = 0; first_req = -1; mask_bad = 0;
        reg_write(8'h98, 4'd8, c);
    endtask

    function automatic bit range_ok(input logic [63:0] a, input logic [63:0] n);
        return (a >= 64'h40000) && (n != 0) && ({1'b0, a} + {1'b0, n} <= 65'h41000);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 65536; i++) hmem[i] = 8'($urandom);
        for (int i = 0; i < 4096; i++) bmodel[i] = 8'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        reg_read(8'h80, 4'd8, v); chk(v == 0, "R9 src reset", v, 0);
        reg_read(8'h98, 4'd8, v); chk(v == 0, "R9 cmd reset", v, 0);
        chk({irq_req, err_flag, mem_rd_req, mem_wr_req} == 4'b0, "R9 outputs idle",
            {irq_req, err_flag, mem_rd_req, mem_wr_req}, 0);

        // R1 access sizes
        reg_write(8'h80, 4'd8, 64'hFFFF_0000_1234_5678);
        reg_read(8'h80, 4'd8, v); chk(v == 64'hFFFF_0000_1234_5678, "R1 8-byte", v, 64'hFFFF_0000_1234_5678);
        reg_write(8'h80, 4'd4, 64'hAAAA_BBBB_0000_1000);
        reg_read(8'h80, 4'd8, v); chk(v == 64'h1000, "R1 4-byte zero-extend", v, 64'h1000);
        reg_write(8'h80, 4'd2, 64'h7777);
        reg_read(8'h80, 4'd8, v); chk(v == 64'h1000, "R1 bad size ignored", v, 64'h1000);
        reg_read(8'h40, 4'd8, v); chk(v == '1, "R1 unmapped all ones", v, '1);

        // R2/R5/R7 host -> buffer with interrupt
        for (int i = 0; i < 16; i++) hmem[16'h1000 + i] = 8'(i * 7 + 3);
        start(64'h1000, 64'h40000, 16, 64'h5);
        reg_write(8'h80, 4'd8, 64'h5555);              // R3 locked write
        wait_idle();
        for (int i = 0; i < 16; i++) bmodel[i] = 8'(i * 7 + 3);
        chk(rd_hs == 16 && wr_hs == 0, "R2 read strobes", 64'(rd_hs), 16);
        chk(irq_cnt == 1, "R7 irq once", 64'(irq_cnt), 1);
        reg_read(8'h98, 4'd8, v); chk(v == 64'h4, "R7 run cleared", v, 64'h4);
        chk(first_req - cmd_cyc >= START_DELAY, "R5 start delay", 64'(first_req - cmd_cyc), START_DELAY);
        reg_read(8'h80, 4'd8, v); chk(v == 64'h1000, "R3 src locked", v, 64'h1000);

        // R2/R7 buffer -> host without interrupt
        start(64'h40000, 64'h2000, 16, 64'h3);
        wait_idle();
        chk(wr_hs == 16 && rd_hs == 0, "R2 write strobes", 64'(wr_hs), 16);
        for (int i = 0; i < 16; i++) begin
            chk(hmem[16'h2000 + i] == 8'(i * 7 + 3), "R2 copy back", 64'(hmem[16'h2000 + i]), 64'(8'(i * 7 + 3)));
        end
        chk(irq_cnt == 0, "R7 no irq", 64'(irq_cnt), 0);

        // R4 command write with bit 0 clear
        reg_write(8'h98, 4'd8, 64'h6);
        reg_read(8'h98, 4'd8, v); chk(v == 64'h2, "R4 cmd discarded", v, 64'h2);

        // R8 window edges
        start(64'h1000, 64'h40FF0, 17, 64'h5);
        wait_idle();
        chk(rd_hs == 0 && err_flag == 1, "R8 one past end rejected", 64'(rd_hs), 0);
        chk(irq_cnt == 0, "R8 reject no irq", 64'(irq_cnt), 0);
        reg_read(8'h98, 4'd8, v); chk(v[0] == 0, "R8 run cleared", v, 64'h4);
        start(64'h1000, 64'h40FF0, 16, 64'h1);
        wait_idle();
        for (int i = 0; i < 16; i++) bmodel[12'hFF0 + i] = hmem[16'h1000 + i];
        chk(rd_hs == 16 && err_flag == 0, "R8 end-exact accepted", 64'(rd_hs), 16);
        start(64'h1000, 64'h3FFFF, 4, 64'h1);
        wait_idle();
        chk(rd_hs == 0 && err_flag == 1, "R8 below window", 64'(rd_hs), 0);
        start(64'h1000, 64'h40000, 0, 64'h1);
        wait_idle();
        chk(rd_hs == 0 && err_flag == 1, "R8 zero count", 64'(rd_hs), 0);

        // R6 host address mask
        start(64'h1234_5678_0000_3000, 64'h40100, 8, 64'h1);
        wait_idle();
        for (int i = 0; i < 8; i++) bmodel[12'h100 + i] = hmem[16'h3000 + i];
        chk(first_addr == 64'h3000, "R6 masked address", first_addr, 64'h3000);
        chk(mask_bad == 0 && rd_hs == 8, "R6 no high bits", 64'(mask_bad), 0);

        // random transfers against the buffer model (R2, R8)
        for (int t = 0; t < 40; t++) begin
            logic [63:0] dev, host, n;
            bit dir, ok;
            dir  = 1'($urandom);
            dev  = 64'h3FFF0 + 64'($urandom % 4200);
            n    = 64'($urandom % 40);
            host = 64'h4000 + 64'($urandom % 32768);
            ok   = range_ok(dev, n);
            if (dir) start(dev, host, n, 64'h3);
            else     start(host, dev, n, 64'h1);
            wait_idle();
            if (!ok) begin
                chk(rd_hs == 0 && wr_hs == 0 && err_flag, "R8 random reject", 64'(rd_hs + wr_hs), 0);
            end else if (!dir) begin
                chk(rd_hs == int'(n) && !err_flag, "R2 random fill", 64'(rd_hs), n);
                for (int i = 0; i < int'(n); i++) bmodel[12'(dev - 64'h40000) + 12'(i)] = hmem[16'(host) + 16'(i)];
            end else begin
                bit same = 1;
                for (int i = 0; i < int'(n); i++)
                    if (hmem[16'(host) + 16'(i)] != bmodel[12'(dev - 64'h40000) + 12'(i)]) same = 0;
                chk(wr_hs == int'(n) && same, "R2 random drain", 64'(wr_hs), n);
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule